// File: doc/BRIEF.md
# Holding-Register Slave Responder

This block answers register-access requests on a serial field bus. A frame receiver upstream has already checked framing and the checksum. It presents the slave address, the function code and the first two 16-bit payload words of a request for one cycle. The responder serves the request from a small internal bank of 16-bit holding registers. It then emits the complete reply frame one byte at a time on a ready/valid output that feeds a UART transmitter. The reply ends with its checksum.

Two operations are supported: reading a block of consecutive registers, and writing a single register. A successful write is answered with an exact copy of the request. A request sent to address 0 is a broadcast. A broadcast write still changes the bank, but the responder emits nothing for any broadcast.

Malformed or unsupported requests receive a short exception reply. It carries the function code with bit 7 set and one code byte. One register in the bank acts as a write-protect latch: while it does not hold 1, every other register refuses writes.

Top module: `regbank_responder`

## Requirements
- R1: A request with function 0x03 (req_w0 = first register, req_w1 = count N) is answered with these bytes, in order: the slave address, 0x03, the byte count 2·N, then the N registers, each sent high byte before low byte. A count of 17 therefore gives a byte count of 0x22.
- R2: Every reply ends with a 16-bit checksum over all preceding reply bytes. The checksum starts at 0xFFFF. For each byte, the byte is XORed into the low half, then eight steps follow; each step shifts right and XORs 0xA001 when the bit shifted out was 1. The low checksum byte is sent before the high byte. Example: the reply 01 06 00 17 00 01 ends in F8 0E.
- R3: A request with function 0x06 (req_w0 = register, req_w1 = value) stores the value. It is answered with eight bytes: the slave address, 0x06, the register high/low, the value high/low, then the checksum.
- R4: A request with slave address 0 never produces output and leaves req_ready high. A broadcast 0x06 write that passes the checks still updates the register.
- R5: A 0x03 request with a count of 0 or a count above 125 gets exception code 0x03.
- R6: A 0x03 request whose range (first + count) passes the end of the 32-entry bank gets exception code 0x02. So does a 0x06 request to a register at or above 32.
- R7: Any function code other than 0x03 and 0x06 gets exception code 0x01.
- R8: Register 23 (0x0017) can always be written. Writes to any other register succeed only while register 23 holds 1. Otherwise they get exception code 0x04 and leave the register unchanged.
- R9: An exception reply is five bytes: the slave address, the function code with bit 7 set, the exception code, then the checksum.
- R10: tx_data and tx_last stay constant while tx_valid is high and tx_ready is low. tx_last marks only the final byte of a frame. req_ready is low from acceptance until that final byte is taken.
- R11: After reset every register reads 0, tx_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A validated request is presented |
| req_ready | output | 1 | Responder is idle and takes the request this cycle |
| req_addr | input | 8 | Slave address of the request (0 = broadcast) |
| req_func | input | 8 | Function code |
| req_w0 | input | 16 | First payload word: start register or target register |
| req_w1 | input | 16 | Second payload word: register count or write value |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| tx_data | output | 8 | Reply byte |
| tx_last | output | 1 | Byte is the final one of the reply frame |

## Verification
Several properties are checked on every cycle. A stalled output byte must hold its value. Nothing may appear on the output the cycle after a broadcast is accepted. The output must fall idle after the final byte is taken. The bank must accept no write to an unprotected register while the protect latch is clear.

Other behaviour shows only through the bench's scenarios. These are the exact byte order of read, echo and exception frames, the checksum values, the byte count for every legal start and count, and the choice between exception codes 0x01 to 0x04. They also include the fact that refused or broadcast writes do or do not reach the bank, which is seen by reading the registers back.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [1:0] {
    RK_READ = 2'd0,
    RK_ECHO = 2'd1,
    RK_EXC  = 2'd2
  } rsp_kind_e;

  localparam logic [7:0] FN_RD_HOLD = 8'h03;
  localparam logic [7:0] FN_WR_ONE  = 8'h06;

  localparam logic [7:0] EX_FUNC   = 8'h01;
  localparam logic [7:0] EX_ADDR   = 8'h02;
  localparam logic [7:0] EX_VALUE  = 8'h03;
  localparam logic [7:0] EX_LOCKED = 8'h04;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'hA001;

  // One byte through the reflected checksum register.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] t;
    t = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      t = t[0] ? ((t >> 1) ^ CRC_POLY) : (t >> 1);
    end
    return t;
  endfunction

endpackage

// File: rtl/rr_decode.sv
module rr_decode
  import rr_pkg::*;
#(
  parameter int NREG = 32,
  parameter int MAXQ = 125,
  parameter int PROT = 23,
  parameter int LW   = 8
) (
  input  logic [7:0]    func,
  input  logic [15:0]   w0,
  input  logic [15:0]   w1,
  input  logic          prot_on,
  output rsp_kind_e     kind,
  output logic [7:0]    exc_code,
  output logic [LW-1:0] len,
  output logic          wr_ok
);

  logic [16:0] rd_end;
  assign rd_end = {1'b0, w0} + {1'b0, w1};

  always_comb begin
    kind     = RK_EXC;
    exc_code = EX_FUNC;
    len      = LW'(5);
    wr_ok    = 1'b0;
    case (func)
      FN_RD_HOLD: begin
        if (w1 == 16'd0 || w1 > 16'(MAXQ)) begin
          exc_code = EX_VALUE;
        end else if (rd_end > 17'(NREG)) begin
          exc_code = EX_ADDR;
        end else begin
          kind = RK_READ;
          len  = LW'(5) + LW'({w1, 1'b0});
        end
      end
      FN_WR_ONE: begin
        if (w0 >= 16'(NREG)) begin
          exc_code = EX_ADDR;
        end else if (w0 != 16'(PROT) && !prot_on) begin
          exc_code = EX_LOCKED;
        end else begin
          kind  = RK_ECHO;
          len   = LW'(8);
          wr_ok = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rr_bank.sv
module rr_bank #(
  parameter int NREG = 32,
  parameter int PROT = 23,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata,
  output logic          prot_on
);

  logic [15:0] regs_w [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic        hit;
    logic [15:0] q;
    assign hit = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        q <= wdata;
      end
    end
    assign regs_w[g] = q;
  end

  assign rdata   = regs_w[raddr];
  assign prot_on = (regs_w[PROT] == 16'd1);

  // R8: no write may reach an ordinary register while the latch is clear
  p_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != AW'(PROT)) |-> prot_on);

endmodule

// File: rtl/rr_crc.sv
module rr_crc
  import rr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr) begin
      crc_d = CRC_SEED;
    end else if (en) begin
      crc_d = crc_step(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (clr || en) begin
      crc_q <= crc_d;
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/rr_tx.sv
module rr_tx
  import rr_pkg::*;
#(
  parameter int AW = 5,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [7:0]    acc_addr,
  input  logic [7:0]    acc_func,
  input  logic [15:0]   acc_w0,
  input  logic [15:0]   acc_w1,
  input  rsp_kind_e     acc_kind,
  input  logic [7:0]    acc_exc,
  input  logic [LW-1:0] acc_len,
  input  logic [15:0]   crc,
  input  logic [15:0]   rdata,
  output logic [AW-1:0] raddr,
  output logic          crc_en,
  output logic          busy,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last
);

  logic          busy_q, busy_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [LW-1:0] len_q;
  rsp_kind_e     kind_q;
  logic [7:0]    exc_q, addr_q, func_q;
  logic [15:0]   w0_q, w1_q;
  logic          load, at_last, at_crc_lo, in_body;
  logic [LW-1:0] rel;

  assign load      = acc && (acc_addr != 8'h00);
  assign at_last   = (idx_q == len_q - LW'(1));
  assign at_crc_lo = (idx_q == len_q - LW'(2));
  assign in_body   = (idx_q < len_q - LW'(2));

  // sequencing next state
  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q && tx_ready) begin
      if (at_last) begin
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  // request fields, captured on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      kind_q <= RK_EXC;
      exc_q  <= '0;
      addr_q <= '0;
      func_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
    end else if (load) begin
      len_q  <= acc_len;
      kind_q <= acc_kind;
      exc_q  <= acc_exc;
      addr_q <= acc_addr;
      func_q <= acc_func;
      w0_q   <= acc_w0;
      w1_q   <= acc_w1;
    end
  end

  assign rel   = idx_q - LW'(3);
  assign raddr = AW'(w0_q + 16'(rel >> 1));

  // byte selection by position in the frame
  always_comb begin
    tx_data = 8'h00;
    if (at_last) begin
      tx_data = crc[15:8];
    end else if (at_crc_lo) begin
      tx_data = crc[7:0];
    end else if (idx_q == LW'(0)) begin
      tx_data = addr_q;
    end else if (idx_q == LW'(1)) begin
      tx_data = (kind_q == RK_EXC) ? (func_q | 8'h80) : func_q;
    end else if (idx_q == LW'(2)) begin
      case (kind_q)
        RK_READ: tx_data = {w1_q[6:0], 1'b0};
        RK_ECHO: tx_data = w0_q[15:8];
        default: tx_data = exc_q;
      endcase
    end else if (kind_q == RK_READ) begin
      tx_data = rel[0] ? rdata[7:0] : rdata[15:8];
    end else begin
      case (idx_q)
        LW'(3):  tx_data = w0_q[7:0];
        LW'(4):  tx_data = w1_q[15:8];
        default: tx_data = w1_q[7:0];
      endcase
    end
  end

  assign busy     = busy_q;
  assign tx_valid = busy_q;
  assign tx_last  = busy_q && at_last;
  assign crc_en   = busy_q && tx_ready && in_body;

  // R10: a stalled byte holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R10: the frame ends after its final byte is taken
  p_end_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

  // R4: broadcast acceptance never starts output
  p_bcast_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_addr == 8'h00) |=> !tx_valid);

endmodule

// File: rtl/regbank_responder.sv
module regbank_responder
  import rr_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int MAXQ     = 125,
  parameter int PROT_REG = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_func,
  input  logic [15:0] req_w0,
  input  logic [15:0] req_w1,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last
);

  localparam int AW = $clog2(NREG);
  localparam int LW = $clog2(2 * MAXQ + 6);

  logic [1:0]    rst_sync;
  logic          rst_n_s;
  logic          busy, acc, we, prot_on, wr_ok, crc_en;
  rsp_kind_e     kind;
  logic [7:0]    exc_code;
  logic [LW-1:0] len;
  logic [AW-1:0] raddr;
  logic [15:0]   rdata, crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync[1];

  assign req_ready = !busy;
  assign acc       = req_valid && !busy;
  assign we        = acc && wr_ok;

  rr_decode #(.NREG(NREG), .MAXQ(MAXQ), .PROT(PROT_REG), .LW(LW)) u_dec (
    .func(req_func), .w0(req_w0), .w1(req_w1), .prot_on(prot_on),
    .kind(kind), .exc_code(exc_code), .len(len), .wr_ok(wr_ok)
  );

  rr_bank #(.NREG(NREG), .PROT(PROT_REG), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .we(we), .waddr(AW'(req_w0)), .wdata(req_w1),
    .raddr(raddr), .rdata(rdata), .prot_on(prot_on)
  );

  rr_crc u_crc (
    .clk(clk), .rst_n(rst_n_s), .clr(acc), .en(crc_en), .din(tx_data), .crc(crc)
  );

  rr_tx #(.AW(AW), .LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .acc(acc), .acc_addr(req_addr), .acc_func(req_func),
    .acc_w0(req_w0), .acc_w1(req_w1), .acc_kind(kind), .acc_exc(exc_code),
    .acc_len(len), .crc(crc), .rdata(rdata), .raddr(raddr), .crc_en(crc_en),
    .busy(busy), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last)
  );

endmodule

// File: tb/regbank_responder_test.sv
`timescale 1ns/1ps
module regbank_responder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [7:0]  req_addr, req_func;
  logic [15:0] req_w0, req_w1;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;

  always #2 clk = ~clk;

  regbank_responder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_func(req_func), .req_w0(req_w0), .req_w1(req_w1),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  int          tests = 0;
  int          fails = 0;
  logic [7:0]  exp_b [0:300];
  logic [7:0]  got_b [0:300];
  int          exp_n, got_n;
  logic [15:0] model [0:31];
  logic [15:0] lfsr = 16'hACE1;
  bit          timed_out, overlap;

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, exp_b[i]};
      for (int k = 0; k < 8; k++) begin
        if (c[0]) c = (c >> 1) ^ 16'hA001;
        else      c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic push(input logic [7:0] b);
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic seal();
    logic [15:0] c;
    c = ref_crc(exp_n);
    push(c[7:0]);
    push(c[15:8]);
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] f,
                      input logic [15:0] w0, input logic [15:0] w1);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_func = f; req_w0 = w0; req_w1 = w1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect();
    timed_out = 0; overlap = 0; got_n = 0;
    for (int k = 0; k < 2000; k++) begin
      tx_ready = lfsr[0] | lfsr[1];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (tx_valid && req_ready) overlap = 1;
      if (tx_valid && tx_ready) begin
        got_b[got_n] = tx_data;
        got_n++;
        if (tx_last) begin
          @(negedge clk);
          return;
        end
      end
      @(negedge clk);
    end
    timed_out = 1;
  endtask

  task automatic check_frame(input string tag);
    int bad_i;
    bad_i = -1;
    tests++;
    if (!timed_out && got_n == exp_n) begin
      for (int i = 0; i < exp_n; i++)
        if (bad_i < 0 && got_b[i] !== exp_b[i]) bad_i = i;
    end
    if (timed_out || overlap || got_n != exp_n || bad_i >= 0) begin
      fails++;
      if (bad_i >= 0)
        $display("FAIL %s byte %0d got %02h expected %02h", tag, bad_i, got_b[bad_i], exp_b[bad_i]);
      else
        $display("FAIL %s length got %0d expected %0d (timeout=%0d ready_overlap=%0d expected 0)",
                 tag, got_n, exp_n, timed_out, overlap);
    end
  endtask

  task automatic do_read(input logic [7:0] a, input int start, input int qty, input string tag);
    exp_n = 0;
    push(a); push(8'h03); push(8'(2 * qty));
    for (int i = 0; i < qty; i++) begin
      push(model[start + i][15:8]);
      push(model[start + i][7:0]);
    end
    seal();
    send(a, 8'h03, 16'(start), 16'(qty));
    collect();
    check_frame(tag);
  endtask

  task automatic do_write(input logic [7:0] a, input int r, input logic [15:0] v, input string tag);
    exp_n = 0;
    push(a); push(8'h06); push(8'(r >> 8)); push(8'(r)); push(v[15:8]); push(v[7:0]);
    seal();
    model[r] = v;
    send(a, 8'h06, 16'(r), v);
    collect();
    check_frame(tag);
  endtask

  task automatic do_exc(input logic [7:0] a, input logic [7:0] f, input logic [15:0] w0,
                        input logic [15:0] w1, input logic [7:0] code, input string tag);
    exp_n = 0;
    push(a); push(f | 8'h80); push(code);
    seal();
    send(a, f, w0, w1);
    collect();
    check_frame(tag);
  endtask

  task automatic do_silent(input logic [7:0] f, input logic [15:0] w0, input logic [15:0] w1,
                           input string tag);
    bit seen;
    seen = 0;
    send(8'h00, f, w0, w1);
    for (int k = 0; k < 30; k++) begin
      tx_ready = k[0];
      #1;
      if (tx_valid || !req_ready) seen = 1;
      @(negedge clk);
    end
    tests++;
    if (seen) begin
      fails++;
      $display("FAIL %s broadcast produced activity: got 1 expected 0", tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R10) run not finished: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_func = '0;
    req_w0 = '0; req_w1 = '0; tx_ready = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    tests++;
    if (tx_valid !== 1'b0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R11 reset outputs got valid=%b ready=%b expected valid=0 ready=1", tx_valid, req_ready);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: whole bank reads zero after reset
    do_read(8'h01, 0, 32, "R11 reset bank contents");

    // R2 / R3: checksum known vectors
    do_write(8'h01, 23, 16'h0001, "R3 R2 unlock echo");
    tests++;
    if (got_b[6] !== 8'hF8 || got_b[7] !== 8'h0E) begin
      fails++;
      $display("FAIL R2 unlock checksum got %02h %02h expected F8 0E", got_b[6], got_b[7]);
    end
    do_write(8'h01, 23, 16'h0000, "R3 R2 lock echo");
    tests++;
    if (got_b[6] !== 8'h39 || got_b[7] !== 8'hCE) begin
      fails++;
      $display("FAIL R2 lock checksum got %02h %02h expected 39 CE", got_b[6], got_b[7]);
    end

    // R8: locked bank refuses and keeps the value
    do_exc(8'h01, 8'h06, 16'd5, 16'h1234, 8'h04, "R8 locked write refused");
    do_exc(8'h09, 8'h06, 16'd0, 16'hFFFF, 8'h04, "R8 locked write reg0");
    do_read(8'h01, 0, 8, "R8 locked registers unchanged");
    do_write(8'h01, 23, 16'h0001, "R8 unlock");

    // R3: sweep writes over the bank
    for (int r = 0; r < 32; r++) begin
      if (r != 23) do_write(8'(r * 5 + 2), r, 16'(r * 16'h1357) ^ 16'hA5C3, "R3 write sweep");
    end

    // R1: every legal start and count
    for (int s = 0; s < 32; s++) begin
      for (int q = 1; q <= 32 - s; q++) begin
        do_read(8'(s * 7 + 1), s, q, "R1 read sweep");
      end
    end
    do_read(8'h01, 7, 17, "R1 seventeen registers");
    tests++;
    if (got_b[2] !== 8'h22) begin
      fails++;
      $display("FAIL R1 byte count got %02h expected 22", got_b[2]);
    end

    // R5 / R6 / R7 / R9: exception replies
    do_exc(8'h01, 8'h03, 16'd0, 16'd0,   8'h03, "R5 R9 count zero");
    do_exc(8'h01, 8'h03, 16'd0, 16'd126, 8'h03, "R5 count 126");
    do_exc(8'h22, 8'h03, 16'd0, 16'hFFFF, 8'h03, "R5 count max");
    do_exc(8'h01, 8'h03, 16'd30, 16'd3,  8'h02, "R6 range overrun");
    do_exc(8'h01, 8'h03, 16'd32, 16'd1,  8'h02, "R6 start past end");
    do_exc(8'h01, 8'h03, 16'hFFFF, 16'd2, 8'h02, "R6 start wrap");
    do_exc(8'h01, 8'h06, 16'd32, 16'd1,  8'h02, "R6 write past end");
    do_exc(8'h01, 8'h06, 16'h0100, 16'd1, 8'h02, "R6 write high addr");
    do_exc(8'h01, 8'h01, 16'd0, 16'd1,   8'h01, "R7 func 01");
    do_exc(8'h01, 8'h04, 16'd0, 16'd1,   8'h01, "R7 func 04");
    do_exc(8'h05, 8'h10, 16'd0, 16'd1,   8'h01, "R7 func 10");
    do_exc(8'h01, 8'h00, 16'd0, 16'd0,   8'h01, "R7 func 00");
    do_read(8'h01, 0, 32, "R6 bank intact after exceptions");

    // R4: broadcast writes land silently, broadcast reads stay silent
    do_silent(8'h06, 16'd7, 16'hBEEF, "R4 broadcast write");
    model[7] = 16'hBEEF;
    do_silent(8'h03, 16'd0, 16'd4, "R4 broadcast read");
    do_silent(8'h2B, 16'd0, 16'd0, "R4 broadcast bad function");
    do_read(8'h01, 6, 3, "R4 broadcast write visible");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule